// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave side of a small serial memory reached over a four-wire SPI bus. It runs on a fast system clock. It oversamples the serial clock, the select, the data-in and the write-protect pin through synchronizer stages, and it works out each serial clock edge from the sampled levels. When select falls, the block notes whether the serial clock is idling low or high. This tells it which of the two supported clock modes the host is using. In both modes, bits are sampled on the rising edge and the output bit changes on the falling edge.

The first byte of a select window is the opcode. Read-data and write-data then take a 24-bit address, of which only the bits that index the internal array are used. After the address they stream any number of bytes, and the address steps after each byte and wraps to zero at the top of the array. A status byte holds four parts: a status-write lock bit, a two-bit protected-region field, a write-enable latch and four free user bits. Writes are governed by the write-enable latch, the status-write lock bit combined with a write-protect pin, and the protected-region field. A sleep state shuts out every opcode except the wake opcode.

Top module: `spi_mem_slave`

## Requirements
- R1: Mode 0 (clock low when select falls) and Mode 3 (clock high when select falls) both work. Data in is taken on rising clock edges and data out changes on falling clock edges, so the first output bit is valid before the first rising edge of its byte.
- R2: Only the first byte of a select window is decoded as the opcode. Later bytes never start a second command (write enable followed by 04h in one window still leaves the latch set).
- R3: Opcode 06h sets the write-enable latch (status bit 1) and 04h clears it. Opcode 05h returns the status byte MSB first as the single byte after the opcode. The output enable is high for those 8 bits and low for any byte after it.
- R4: Write-data (02h) and write-status (01h) change nothing while the latch is clear. When select rises on a byte boundary after at least one data byte of either command, the latch clears.
- R5: Write-status stores bits 7, 6, 5, 4, 3, 2 and 0 of its data byte; bit 1 is not writable through it. The write is refused when status bit 7 is 1 and the write-protect input is low.
- R6: Status bits 3:2 lock a region against data writes. Value 0 locks nothing, 1 locks the top quarter of the array, 2 locks the top half and 3 locks the whole array. Writes to locked bytes are dropped and writes to other bytes go through.
- R7: Read-data (03h) and write-data (02h) take three address bytes, MSB first, and use the low address bits. They then move any number of bytes, and the address advances by one per byte and wraps from the last location to 0.
- R8: A byte that is not complete when select rises is never committed. The end-of-command actions (set or clear the latch, enter or leave sleep) happen only when select rises a multiple of 8 clocks after it fell.
- R9: Opcode B9h enters sleep and ABh leaves it. While asleep every other opcode is ignored and the output enable stays low.
- R10: After reset the status byte and every array byte are 0, and the output enable is low whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_wp_n | input | 1 | Active-low write-protect pin |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Pad drive enable for spi_miso; low means high impedance |

## Verification
The assertions assume that select stays high for at least four system clocks between windows. They also assume that select changes only half a serial period away from any serial clock edge, so the synchronized select and clock never move in the same cycle. The bench drives every serial edge six system clocks apart, which leaves each transition well clear of the three-register sampling path. It holds select steady for a full half period before and after each edge. The write-protect pin is changed only while select is high.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [3:0] {
    CMD_NONE,
    CMD_WREN,
    CMD_WRDI,
    CMD_RDSR,
    CMD_WRSR,
    CMD_READ,
    CMD_WRITE,
    CMD_SLEEP,
    CMD_WAKE
  } cmd_e;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_WAKE  = 8'hAB;

  // Status byte bit positions
  localparam int ST_LOCK = 7;
  localparam int ST_BPH  = 3;
  localparam int ST_BPL  = 2;
  localparam int ST_WEL  = 1;

  function automatic cmd_e decode_op(logic [7:0] op, logic asleep);
    cmd_e c;
    case (op)
      OPC_WREN:  c = CMD_WREN;
      OPC_WRDI:  c = CMD_WRDI;
      OPC_RDSR:  c = CMD_RDSR;
      OPC_WRSR:  c = CMD_WRSR;
      OPC_READ:  c = CMD_READ;
      OPC_WRITE: c = CMD_WRITE;
      OPC_SLEEP: c = CMD_SLEEP;
      OPC_WAKE:  c = CMD_WAKE;
      default:   c = CMD_NONE;
    endcase
    if (asleep && (op != OPC_WAKE)) c = CMD_NONE;
    return c;
  endfunction

  // top2 holds the two most significant array address bits
  function automatic logic region_locked(logic [1:0] bp, logic [1:0] top2);
    logic r;
    case (bp)
      2'b00:   r = 1'b0;
      2'b01:   r = &top2;
      2'b10:   r = top2[1];
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_mem_status.sv
module spi_mem_status
  import spi_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       sr_wr,
  input  logic [7:0] sr_din,
  input  logic       wp_n,
  input  logic       sleep_set,
  input  logic       sleep_clr,
  output logic [7:0] stat,
  output logic       asleep
);

  logic [7:0] stat_q, stat_d;
  logic       sleep_q, sleep_d;
  logic       sr_allowed;

  assign sr_allowed = stat_q[ST_WEL] && !(stat_q[ST_LOCK] && !wp_n);

  always_comb begin
    stat_d  = stat_q;
    sleep_d = sleep_q;
    if (sr_wr && sr_allowed) begin
      stat_d = {sr_din[7:2], stat_q[ST_WEL], sr_din[0]};
    end
    if (wel_set) stat_d[ST_WEL] = 1'b1;
    if (wel_clr) stat_d[ST_WEL] = 1'b0;
    if (sleep_set) sleep_d = 1'b1;
    if (sleep_clr) sleep_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      sleep_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      sleep_q <= sleep_d;
    end
  end

  assign stat   = stat_q;
  assign asleep = sleep_q;

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int AW = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic spi_wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);

  localparam logic [2:0] IDX_MAX = 3'd5;  // opcode + 3 address + 1 data seen

  logic       sclk_s, cs_s, mosi_s, wp_s;
  logic       sclk_prev_q, cs_prev_q;
  logic       sclk_rise, sclk_fall, cs_fall, cs_rise;

  spi_mem_sync #(
    .W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_wp_n, spi_cs_n, spi_mosi, spi_sclk}),
    .q({wp_s, cs_s, mosi_s, sclk_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      cs_prev_q   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign cs_fall   = ~cs_s & cs_prev_q;
  assign cs_rise   = cs_s & ~cs_prev_q;

  logic          mode3_q, mode3_d;
  logic          seen_q, seen_d;
  logic          act_q, act_d;
  logic [2:0]    bit_cnt_q, bit_cnt_d;
  logic [2:0]    idx_q, idx_d;
  logic [7:0]    rx_q, rx_d, rx_byte;
  cmd_e          cmd_q, cmd_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    tx_q, tx_d;
  logic          oe_q, oe_d;

  logic       wel_set, wel_clr, sr_wr, slp_set, slp_clr, mem_we;
  logic [7:0] stat_w, mem_rdata;
  logic       asleep_w;

  assign rx_byte = {rx_q[6:0], mosi_s};

  always_comb begin
    mode3_d   = mode3_q;
    seen_d    = seen_q;
    act_d     = act_q;
    bit_cnt_d = bit_cnt_q;
    idx_d     = idx_q;
    rx_d      = rx_q;
    cmd_d     = cmd_q;
    addr_d    = addr_q;
    tx_d      = tx_q;
    oe_d      = oe_q;
    wel_set   = 1'b0;
    wel_clr   = 1'b0;
    sr_wr     = 1'b0;
    slp_set   = 1'b0;
    slp_clr   = 1'b0;
    mem_we    = 1'b0;

    if (cs_fall) begin
      mode3_d   = sclk_s;
      seen_d    = 1'b0;
      act_d     = 1'b1;
      bit_cnt_d = '0;
      idx_d     = '0;
      cmd_d     = CMD_NONE;
      oe_d      = 1'b0;
    end else if (cs_s) begin
      oe_d  = 1'b0;
      act_d = 1'b0;
      if (cs_rise && act_q && (bit_cnt_q == '0)) begin
        case (cmd_q)
          CMD_WREN:  wel_set = 1'b1;
          CMD_WRDI:  wel_clr = 1'b1;
          CMD_SLEEP: slp_set = 1'b1;
          CMD_WAKE:  slp_clr = 1'b1;
          CMD_WRITE: wel_clr = (idx_q == IDX_MAX);
          CMD_WRSR:  wel_clr = (idx_q >= 3'd2);
          default:   ;
        endcase
      end
    end else if (act_q) begin
      if (sclk_rise) begin
        seen_d    = 1'b1;
        rx_d      = rx_byte;
        bit_cnt_d = bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          if (idx_q != IDX_MAX) idx_d = idx_q + 3'd1;
          if (idx_q == '0) begin
            cmd_d = decode_op(rx_byte, asleep_w);
          end else begin
            case (cmd_q)
              CMD_READ, CMD_WRITE: begin
                if (idx_q <= 3'd3) begin
                  addr_d = AW'({addr_q, rx_byte});
                end else if (cmd_q == CMD_WRITE) begin
                  mem_we = stat_w[ST_WEL] &&
                           !region_locked(stat_w[ST_BPH:ST_BPL], addr_q[AW-1 -: 2]);
                  addr_d = addr_q + 1'b1;
                end
              end
              CMD_WRSR: sr_wr = (idx_q == 3'd1);
              default:  ;
            endcase
          end
        end
      end else if (sclk_fall && (mode3_q || seen_q)) begin
        if (bit_cnt_q == '0) begin
          oe_d = 1'b0;
          if (cmd_q == CMD_RDSR && idx_q == 3'd1) begin
            tx_d = stat_w;
            oe_d = 1'b1;
          end else if (cmd_q == CMD_READ && idx_q >= 3'd4) begin
            tx_d   = mem_rdata;
            oe_d   = 1'b1;
            addr_d = addr_q + 1'b1;
          end
        end else begin
          tx_d = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode3_q   <= 1'b0;
      seen_q    <= 1'b0;
      act_q     <= 1'b0;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      rx_q      <= '0;
      cmd_q     <= CMD_NONE;
      addr_q    <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
    end else begin
      mode3_q   <= mode3_d;
      seen_q    <= seen_d;
      act_q     <= act_d;
      bit_cnt_q <= bit_cnt_d;
      idx_q     <= idx_d;
      rx_q      <= rx_d;
      cmd_q     <= cmd_d;
      addr_q    <= addr_d;
      tx_q      <= tx_d;
      oe_q      <= oe_d;
    end
  end

  spi_mem_status u_status (
    .clk(clk), .rst_n(rst_n),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .sr_wr(sr_wr), .sr_din(rx_byte), .wp_n(wp_s),
    .sleep_set(slp_set), .sleep_clr(slp_clr),
    .stat(stat_w), .asleep(asleep_w)
  );

  spi_mem_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .addr(addr_q), .wdata(rx_byte),
    .rdata(mem_rdata)
  );

  assign spi_miso    = tx_q[7];
  assign spi_miso_oe = oe_q;

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso_oe,
  input logic       cs_rise,
  input logic [2:0] bit_cnt,
  input logic [7:0] stat,
  input logic       asleep
);

  // R10
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso_oe);

  // R3
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_oe) |-> !spi_cs_n);

  // R4
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(cs_rise));

  // R5
  sr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat[7:2]) |-> $past(stat[1]));

  // R8
  partial_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && (bit_cnt != 3'd0)) |=> ($stable(stat[1]) && $stable(asleep)));

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !spi_miso_oe);

endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .spi_cs_n(spi_cs_n),
  .spi_miso_oe(spi_miso_oe),
  .cs_rise(cs_rise),
  .bit_cnt(bit_cnt_q),
  .stat(stat_w),
  .asleep(asleep_w)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = 6;
  localparam int WATCHDOG = 180000;

  logic clk, rst_n, sclk, cs_n, mosi, wp_n;
  logic miso, miso_oe;

  int  vecs, fails;
  bit  m3, done;
  int  bp_model;
  logic [7:0] exp_mem [DEPTH];

  spi_mem_slave #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_wp_n(wp_n),
    .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    vecs++;
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(int k, int seed);
    return 8'((k * 13) + (seed * 41) + 7);
  endfunction

  function automatic bit locked(int bp, int a);
    case (bp)
      0: return 1'b0;
      1: return a >= DEPTH - DEPTH / 4;
      2: return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic spi_open(bit mode3);
    m3 = mode3;
    sclk = mode3;
    wait_clk(2 * HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic spi_close();
    if (!m3) begin
      sclk = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n,
                          output logic [7:0] rx, output int oe_hi);
    rx = '0;
    oe_hi = 0;
    for (int i = 7; i > 7 - n; i--) begin
      sclk = 1'b0;
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      if (miso_oe) oe_hi++;
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r;
    int h;
    spi_bits(tx, 8, r, h);
  endtask

  task automatic do_cmd(bit mode3, input logic [7:0] op);
    spi_open(mode3);
    send(op);
    spi_close();
  endtask

  task automatic rd_status(bit mode3, output logic [7:0] v,
                           output int hi1, output int hi2);
    logic [7:0] d;
    spi_open(mode3);
    send(8'h05);
    spi_bits(8'h00, 8, v, hi1);
    spi_bits(8'h00, 8, d, hi2);
    spi_close();
  endtask

  task automatic wr_status(bit mode3, input logic [7:0] v);
    do_cmd(mode3, 8'h06);
    spi_open(mode3);
    send(8'h01);
    send(v);
    spi_close();
  endtask

  task automatic write_run(bit mode3, input logic [23:0] addr, int n,
                           int seed, bit wel_on);
    spi_open(mode3);
    send(8'h02);
    send(addr[23:16]);
    send(addr[15:8]);
    send(addr[7:0]);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (int'(addr) + k) % DEPTH;
      send(pat(k, seed));
      if (wel_on && !locked(bp_model, a)) exp_mem[a] = pat(k, seed);
    end
    spi_close();
  endtask

  task automatic read_check(bit mode3, input logic [23:0] addr, int n,
                            string tag);
    logic [7:0] v;
    int hi;
    spi_open(mode3);
    send(8'h03);
    send(addr[23:16]);
    send(addr[15:8]);
    send(addr[7:0]);
    for (int k = 0; k < n; k++) begin
      spi_bits(8'h00, 8, v, hi);
      chk(tag, {24'h0, v}, {24'h0, exp_mem[(int'(addr) + k) % DEPTH]});
      if (k == 0) chk(tag, hi, 8);
    end
    spi_close();
  endtask

  initial begin
    logic [7:0] v, d;
    int h1, h2;
    vecs = 0; fails = 0; done = 1'b0; bp_model = 0;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; wp_n = 1'b1; m3 = 1'b0;
    wait_clk(8);
    chk("R10 oe in reset", {31'h0, miso_oe}, 0);
    rst_n = 1'b1;
    wait_clk(8);

    // R10: reset status
    rd_status(0, v, h1, h2);
    chk("R10 status after reset", v, 8'h00);
    chk("R10 oe with cs high", {31'h0, miso_oe}, 0);

    // R4: write without latch has no effect
    write_run(0, 24'h000000, 2, 1, 0);
    read_check(1, 24'h000000, 2, "R4 write without latch");

    // R3: latch set/clear and single-byte status window
    do_cmd(0, 8'h06);
    rd_status(1, v, h1, h2);
    chk("R3 latch set", v, 8'h02);
    chk("R3 oe during status byte", h1, 8);
    chk("R3 oe after status byte", h2, 0);
    do_cmd(1, 8'h04);
    rd_status(0, v, h1, h2);
    chk("R3 latch clear", v, 8'h00);

    // R7 / R1: streaming write with wrap in Mode 0, read in Mode 3 and Mode 0
    do_cmd(0, 8'h06);
    write_run(0, 24'h12347C, DEPTH + 2, 2, 1);
    rd_status(0, v, h1, h2);
    chk("R4 latch auto clear", v, 8'h00);
    read_check(1, 24'hABCD3C, DEPTH + 4, "R7 stream wrap mode3");
    read_check(0, 24'h000000, 8, "R1 mode0 read");

    // R2: one command per window
    spi_open(1);
    send(8'h06);
    send(8'h04);
    spi_close();
    rd_status(0, v, h1, h2);
    chk("R2 extra byte ignored", v, 8'h02);
    do_cmd(0, 8'h04);

    // R5: status write rules
    wr_status(0, 8'h73);
    rd_status(1, v, h1, h2);
    chk("R5 user bits, bit1 not writable", v, 8'h71);
    wr_status(1, 8'h80);
    rd_status(0, v, h1, h2);
    chk("R5 lock bit set", v, 8'h80);
    wp_n = 1'b0;
    wait_clk(4);
    wr_status(0, 8'h0C);
    rd_status(0, v, h1, h2);
    chk("R5 locked and pin low refuses", v, 8'h80);
    wp_n = 1'b1;
    wait_clk(4);
    wr_status(0, 8'h00);
    rd_status(0, v, h1, h2);
    chk("R5 pin high allows", v, 8'h00);

    // R6: region locks
    for (int bp = 1; bp < 4; bp++) begin
      bit md;
      md = bp[0];
      wr_status(md, 8'(bp << 2));
      bp_model = bp;
      rd_status(md, v, h1, h2);
      chk("R6 field stored", v, 8'(bp << 2));
      do_cmd(md, 8'h06);
      write_run(md, 24'h000000, DEPTH, 3 + bp, 1);
      read_check(!md, 24'h000000, DEPTH, "R6 locked region");
    end
    wr_status(0, 8'h00);
    bp_model = 0;

    // R8: partial trailing bytes
    spi_open(0);
    send(8'h06);
    spi_bits(8'h00, 3, d, h1);
    spi_close();
    rd_status(0, v, h1, h2);
    chk("R8 partial close drops latch set", v, 8'h00);
    do_cmd(1, 8'h06);
    spi_open(1);
    send(8'h02); send(8'h00); send(8'h00); send(8'h0A);
    send(8'hA5);
    spi_bits(8'h3C, 5, d, h1);
    spi_close();
    exp_mem[10] = 8'hA5;
    rd_status(0, v, h1, h2);
    chk("R8 latch kept after partial end", v, 8'h02);
    do_cmd(0, 8'h04);
    read_check(1, 24'h00000A, 2, "R8 partial byte not stored");

    // R9: sleep
    do_cmd(0, 8'hB9);
    rd_status(1, v, h1, h2);
    chk("R9 no output while asleep", h1, 0);
    do_cmd(0, 8'h06);
    do_cmd(1, 8'hAB);
    rd_status(0, v, h1, h2);
    chk("R9 latch set ignored in sleep", v, 8'h00);
    chk("R9 output back after wake", h1, 8);

    summary();
  end

endmodule